// File: doc/BRIEF.md
# Sectored Direct-Mapped Read Cache

This block is a small read-only cache that sits between a requester and a slower memory. Its default geometry is 1 KB of storage in 32 lines of 32 bytes. Each line is divided into four 8-byte sectors. A line holds one address tag, which its four sectors share, and it keeps a separate valid flag for each sector. Each address can live in exactly one line. A line is never chosen: it is fixed by the address.

A read presents an address for one cycle. On a hit, the addressed byte comes back on the next cycle with a one-cycle `hit` strobe. On a miss, the block raises `busy` and asks memory for the 8-byte sector that holds the byte, and only that sector. When memory returns the sector, the block writes it into the line, updates the tag and the valid flags, and completes the read with `hit` on the following cycle. When the tag differs from the one stored, the new tag replaces the old one and the line keeps only the sector just fetched. When the tag matches, the fetched sector is added to the sectors the line already holds.

Top module: `sdc_cache`

## Requirements
- R1: Address fields are fixed. Bits 2:0 pick the byte within a sector (byte k is data bits 8k+7:8k). Bits 4:3 pick the sector. Bits 9:5 pick one of 32 lines. Bits 31:10 form the 22-bit tag, and a difference in any tag bit makes the access a miss.
- R2: After reset every sector is invalid, so the first read of any address misses, and `hit`, `busy` and `fill_req` are 0.
- R3: On a read that misses, `busy` and `fill_req` are 1 in the next cycle. `fill_addr` equals the request address with bits 2:0 cleared, and both stay constant until `fill_valid` is sampled.
- R4: In the cycle after `fill_valid` is sampled, `hit` is 1 for exactly one cycle, `busy` and `fill_req` are 0, and `rd_data` is the addressed byte of `fill_data`.
- R5: A read whose tag matches the line and whose sector is valid gives `hit`=1 and the stored byte in the next cycle, with no fill request.
- R6: When the tag matches but the addressed sector is invalid, only that sector is fetched. Sectors of the line that were already valid still hit afterwards.
- R7: When the tag differs, the fill installs the new tag and clears the line's other sectors. A later read under the old tag misses, and so does any sector of the new tag other than the one fetched.
- R8: Lines at different indices are independent: filling one does not change hits on another.
- R9: A request raised while `busy` is 1 is ignored. It changes neither `fill_addr` nor the response, and it produces no later response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Byte address of the read |
| hit | output | 1 | One-cycle strobe: `rd_data` holds the result |
| busy | output | 1 | Miss in progress, requests ignored |
| rd_data | output | 8 | Byte read |
| fill_req | output | 1 | Sector fetch request to memory |
| fill_addr | output | 32 | Sector-aligned fetch address |
| fill_valid | input | 1 | Memory returns the sector this cycle |
| fill_data | input | 64 | Returned sector, byte k at bits 8k+7:8k |

## Verification
The case that is hardest to reach from the ports is a line that holds a mix of valid and invalid sectors under one tag, followed by a conflicting tag that must wipe that mix. The stimulus builds such a line first: a cold miss on one sector, a hit on it, and then a second-sector miss under the same tag. It then reads a conflicting address at the same index and returns to the first tag. Reads of both previously valid sectors must now miss and fetch again. A request poked in the middle of a pending fill checks that the controller stays locked until the memory answers.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sdc_state_e;

    function automatic logic [7:0] sdc_pick_byte(input logic [63:0] sec, input logic [2:0] ofs);
        logic [63:0] sh;
        sh = sec >> {ofs, 3'b000};
        return sh[7:0];
    endfunction
endpackage

// File: rtl/sdc_tag_store.sv
module sdc_tag_store #(
    parameter int LINES   = 32,
    parameter int SECTORS = 4,
    parameter int TAG_W   = 22,
    localparam int IDX_W  = $clog2(LINES),
    localparam int SEC_W  = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [SEC_W-1:0] lk_sec,
    output logic             lk_hit,
    output logic             lk_tag_match,
    input  logic             wr_en,
    input  logic             wr_keep,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SEC_W-1:0] wr_sec
);
    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [SECTORS-1:0] vld;
    } line_t;

    logic [TAG_W-1:0]   tag_arr [LINES];
    logic [SECTORS-1:0] vld_arr [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && (wr_idx == IDX_W'(l))) begin
                if (!wr_keep) begin
                    line_d.tag = wr_tag;
                    line_d.vld = '0;
                end
                line_d.vld[wr_sec] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else begin
                line_q <= line_d;
            end
        end

        assign tag_arr[l] = line_q.tag;
        assign vld_arr[l] = line_q.vld;
    end

    assign lk_tag_match = (tag_arr[lk_idx] == lk_tag);
    assign lk_hit       = lk_tag_match && vld_arr[lk_idx][lk_sec];

    AST_REPLACE_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_keep |=> $countones(vld_arr[$past(wr_idx)]) == 1) else $error("replace left extra sectors"); // R7

    AST_KEEP_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_keep |=> $countones(vld_arr[$past(wr_idx)]) >= $countones($past(vld_arr[wr_idx]))) else $error("keep fill dropped sectors"); // R6
endmodule

// File: rtl/sdc_data_store.sv
module sdc_data_store #(
    parameter int LINES   = 32,
    parameter int SECTORS = 4,
    parameter int SEC_DW  = 64,
    localparam int IDX_W  = $clog2(LINES),
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int DEPTH  = LINES * SECTORS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEC_W-1:0]  rd_sec,
    output logic [SEC_DW-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [SEC_DW-1:0] wr_data
);
    logic [SEC_DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_sec}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_sec}];
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEC_OFS = 3,
    localparam int SEC_DW = 8 << SEC_OFS,
    localparam int PEND_W = ADDR_W - SEC_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              lk_hit,
    input  logic              lk_tag_match,
    input  logic [SEC_DW-1:0] lk_sec_data,
    input  logic              fill_valid,
    input  logic [SEC_DW-1:0] fill_data,
    output logic [PEND_W-1:0] pend_sec,
    output logic              wr_en,
    output logic              wr_keep,
    output logic              hit,
    output logic              busy,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        sdc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              keep;
        logic              hit;
        logic [7:0]        data;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        wr_en    = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.addr = req_addr;
                    if (lk_hit) begin
                        st_d.hit  = 1'b1;
                        st_d.data = sdc_pick_byte(64'(lk_sec_data), 3'(req_addr[SEC_OFS-1:0]));
                    end else begin
                        st_d.state = ST_WAIT;
                        st_d.keep  = lk_tag_match;
                    end
                end
            end
            default: begin
                if (fill_valid) begin
                    wr_en      = 1'b1;
                    st_d.state = ST_IDLE;
                    st_d.hit   = 1'b1;
                    st_d.data  = sdc_pick_byte(64'(fill_data), 3'(st_q.addr[SEC_OFS-1:0]));
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_sec = st_q.addr[ADDR_W-1:SEC_OFS];
    assign wr_keep  = st_q.keep;
    assign hit      = st_q.hit;
    assign busy     = (st_q.state == ST_WAIT);
    assign rd_data  = st_q.data;

    AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && !lk_hit |=> busy && !hit) else $error("miss did not start fill"); // R3

    AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fill_valid |=> busy && $stable(pend_sec)) else $error("pending sector moved"); // R3

    AST_FILL_ENDS_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && fill_valid |=> hit && !busy) else $error("fill did not complete read"); // R4

    AST_NO_HIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !hit) else $error("response during fill"); // R9

    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && lk_hit |=> hit && !busy) else $error("hit started a fill"); // R5
endmodule

// File: rtl/sdc_cache.sv
module sdc_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SEC_BYTES  = 8,
    parameter int LINES      = 32,
    localparam int LINE_OFS  = $clog2(LINE_BYTES),
    localparam int SEC_OFS   = $clog2(SEC_BYTES),
    localparam int SECTORS   = LINE_BYTES / SEC_BYTES,
    localparam int SEC_W     = $clog2(SECTORS),
    localparam int IDX_W     = $clog2(LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - LINE_OFS,
    localparam int SEC_DW    = 8 * SEC_BYTES,
    localparam int PEND_W    = ADDR_W - SEC_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic              busy,
    output logic [7:0]        rd_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [SEC_DW-1:0] fill_data
);
    logic [IDX_W-1:0]  lk_idx, wr_idx;
    logic [TAG_W-1:0]  lk_tag, wr_tag;
    logic [SEC_W-1:0]  lk_sec, wr_sec;
    logic              lk_hit, lk_tag_match;
    logic [SEC_DW-1:0] lk_sec_data;
    logic [PEND_W-1:0] pend_sec;
    logic              wr_en, wr_keep;

    assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_idx = req_addr[LINE_OFS +: IDX_W];
    assign lk_sec = req_addr[SEC_OFS +: SEC_W];

    assign wr_tag = pend_sec[PEND_W-1 -: TAG_W];
    assign wr_idx = pend_sec[(LINE_OFS - SEC_OFS) +: IDX_W];
    assign wr_sec = pend_sec[0 +: SEC_W];

    assign fill_req  = busy;
    assign fill_addr = {pend_sec, {SEC_OFS{1'b0}}};

    sdc_tag_store #(
        .LINES   (LINES),
        .SECTORS (SECTORS),
        .TAG_W   (TAG_W)
    ) tags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_idx       (lk_idx),
        .lk_tag       (lk_tag),
        .lk_sec       (lk_sec),
        .lk_hit       (lk_hit),
        .lk_tag_match (lk_tag_match),
        .wr_en        (wr_en),
        .wr_keep      (wr_keep),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_sec       (wr_sec)
    );

    sdc_data_store #(
        .LINES   (LINES),
        .SECTORS (SECTORS),
        .SEC_DW  (SEC_DW)
    ) data_i (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_sec  (lk_sec),
        .rd_data (lk_sec_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sec  (wr_sec),
        .wr_data (fill_data)
    );

    sdc_ctrl #(
        .ADDR_W  (ADDR_W),
        .SEC_OFS (SEC_OFS)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .lk_hit       (lk_hit),
        .lk_tag_match (lk_tag_match),
        .lk_sec_data  (lk_sec_data),
        .fill_valid   (fill_valid),
        .fill_data    (fill_data),
        .pend_sec     (pend_sec),
        .wr_en        (wr_en),
        .wr_keep      (wr_keep),
        .hit          (hit),
        .busy         (busy),
        .rd_data      (rd_data)
    );

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> fill_addr[SEC_OFS-1:0] == '0) else $error("fill address not aligned"); // R3
endmodule

// File: tb/sdc_cache_tb.sv
module sdc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit, busy, fill_req;
    logic [7:0]  rd_data;
    logic [31:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [63:0] fill_data = '0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sdc_cache dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .hit        (hit),
        .busy       (busy),
        .rd_data    (rd_data),
        .fill_req   (fill_req),
        .fill_addr  (fill_addr),
        .fill_valid (fill_valid),
        .fill_data  (fill_data)
    );

    function automatic logic [63:0] mem_sec(input logic [31:0] a);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) begin
            v[8*k +: 8] = a[10:3] * 8'd29 + 8'(k) * 8'd11 + a[31:24] + {1'b0, a[17:11]};
        end
        return v;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [63:0] s;
        s = mem_sec({a[31:3], 3'b000});
        return s[8*a[2:0] +: 8];
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input bit exp_hit, input string rq,
                      input bit poke = 1'b0, input logic [31:0] poke_addr = '0);
        logic [31:0] exp_fa;
        exp_fa = {a[31:3], 3'b000};
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(hit == 1'b1, rq, "hit", 64'(hit), 64'd1);
            chk(busy == 1'b0 && fill_req == 1'b0, rq, "no fill on hit", 64'(fill_req), 64'd0);
            chk(rd_data == mem_byte(a), rq, "hit data", 64'(rd_data), 64'(mem_byte(a)));
        end else begin
            chk(hit == 1'b0, rq, "miss no hit", 64'(hit), 64'd0);
            chk(busy == 1'b1 && fill_req == 1'b1, rq, "busy on miss (R3)", 64'({busy, fill_req}), 64'd3);
            chk(fill_addr == exp_fa, rq, "fill addr (R3)", 64'(fill_addr), 64'(exp_fa));
            for (int w = 0; w < 2; w++) begin
                if (poke) begin
                    req_valid = 1'b1;
                    req_addr  = poke_addr;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk(busy == 1'b1 && hit == 1'b0, rq, "wait held (R3)", 64'({busy, hit}), 64'd2);
                chk(fill_addr == exp_fa, rq, "fill addr stable (R3)", 64'(fill_addr), 64'(exp_fa));
            end
            fill_valid = 1'b1;
            fill_data  = mem_sec(fill_addr);
            @(negedge clk);
            fill_valid = 1'b0;
            fill_data  = '0;
            chk(hit == 1'b1 && busy == 1'b0 && fill_req == 1'b0, rq, "fill done (R4)",
                64'({hit, busy, fill_req}), 64'd4);
            chk(rd_data == mem_byte(a), rq, "fill data (R4)", 64'(rd_data), 64'(mem_byte(a)));
        end
        @(negedge clk);
        chk(hit == 1'b0, rq, "hit one cycle", 64'(hit), 64'd0);
        chk(fill_req == 1'b0, rq, "no stray fill", 64'(fill_req), 64'd0);
    endtask

    localparam logic [31:0] A = 32'h0000_0A48;

    task automatic t_reset();
        chk(hit == 1'b0 && busy == 1'b0 && fill_req == 1'b0, "R2", "reset outputs",
            64'({hit, busy, fill_req}), 64'd0);
        rd(A, 1'b0, "R2 cold miss");
    endtask

    task automatic t_hit();
        rd(A + 32'd5, 1'b1, "R5 same sector byte 5");
        rd(A + 32'd2, 1'b1, "R1 byte select bits 2:0");
    endtask

    task automatic t_sector();
        rd(A + 32'd8, 1'b0, "R6 other sector miss");
        rd(A, 1'b1, "R6 first sector kept");
        rd(A + 32'd9, 1'b1, "R6 new sector hit");
    endtask

    task automatic t_conflict();
        rd(A + 32'd1024, 1'b0, "R7 conflicting tag");
        rd(A, 1'b0, "R7 old tag evicted");
        rd(A + 32'd8, 1'b0, "R7 other sectors cleared");
        rd(A ^ 32'h8000_0000, 1'b0, "R1 top tag bit");
    endtask

    task automatic t_index();
        rd(A + 32'd32, 1'b0, "R8 next line miss");
        rd(A ^ 32'h8000_0000, 1'b1, "R8 first line kept");
        rd(A + 32'd32, 1'b1, "R8 next line hit");
    endtask

    task automatic t_busy();
        rd(32'h1234_5670, 1'b0, "R9 miss with poke", 1'b1, 32'h0000_3300);
        rd(32'h0000_3300, 1'b0, "R9 poked addr not loaded");
        rd(32'h1234_5677, 1'b1, "R9 pending addr loaded");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_sector();
        t_conflict();
        t_index();
        t_busy();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule